// File: doc/BRIEF.md
# Zero-Register File with Block Copy

This block is a 256-entry register file of 64-bit words, addressed by an 8-bit index. Two read ports are purely combinational and a single write port updates an entry on the rising clock edge. Entry 0 is a constant zero: reads of it return zero and writes to it are discarded.

A command port starts two kinds of operation. A swap exchanges two entries in a single clock edge. A block copy moves a run of consecutive entries from a source base to a destination base at one entry per cycle. The copy picks its walking direction from the two bases, so a source run and a destination run that overlap without wrapping give the same result as copying from a snapshot. While a copy runs, `busy` is high and new commands are dropped. Every accepted command raises `done` for exactly one cycle when it has finished. The register write port keeps working during a copy.

Top module: `zreg_file`

## Requirements
- R1: The file holds 256 entries of 64 bits. A write with `wr_en` high stores `wr_data` at `wr_idx` on the rising edge, and both read ports show the new value from that edge on.
- R2: Both read ports return zero for index 0, and a write aimed at index 0 changes nothing that can be read back.
- R3: When a port write and a command write hit the same entry on the same edge, the command write wins.
- R4: An accepted command with `cmd_op`=0 (swap) exchanges the entries at `cmd_src` and `cmd_dst` on the accepting edge. `done` is high in the following cycle and `busy` stays low.
- R5: In a swap, if both operands are index 0 nothing changes. If exactly one operand is 0, the other entry becomes zero.
- R6: An accepted command with `cmd_op`=1 (copy) and a nonzero `cmd_len`=N raises `busy` for N cycles and writes one entry per cycle. `done` is high in the cycle after the last write, then low in the cycle after that.
- R7: A copy runs in ascending order when `cmd_dst` < `cmd_src`, and in descending order otherwise. A non-wrapping copy whose source and destination runs overlap therefore gives the result of copying from a snapshot.
- R8: During a copy, indices wrap modulo 256. A source index of 0 supplies zero, and a destination index of 0 is skipped.
- R9: A copy with `cmd_len`=0 changes no entry, never raises `busy`, and pulses `done` in the next cycle.
- R10: A command presented while `busy` is high is ignored, and the entries it names are left unchanged.
- R11: After reset every entry reads zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 8 | Read port A index |
| rd_a_data | output | 64 | Read port A data, combinational |
| rd_b_idx | input | 8 | Read port B index |
| rd_b_data | output | 64 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 8 | Write index |
| wr_data | input | 64 | Write data |
| cmd_valid | input | 1 | Command request; accepted when `busy` is low |
| cmd_op | input | 1 | 0 = swap, 1 = block copy |
| cmd_src | input | 8 | Swap operand A / copy source base |
| cmd_dst | input | 8 | Swap operand B / copy destination base |
| cmd_len | input | 8 | Copy length in entries (0 to 255) |
| busy | output | 1 | A block copy is in progress |
| done | output | 1 | One-cycle pulse when a command finishes |

## Verification
Each fault in the block leaves traces at the ports. A wrong walk direction or a wrong pointer step in the copy engine leaves stale or duplicated words in the overlapped part of the destination. A read-back of all entries shows this as soon as `done` pulses. A remaining-count error shows up right away as `busy` lasting too many or too few cycles, or as `done` arriving on the wrong cycle. A broken zero rule shows up at the first read of index 0, or of the swap partner of index 0, after that edge. A command that slips through while `busy` is high corrupts the entries it names, and those entries are read back after the copy ends.

// File: rtl/zreg_file.sv
module zreg_file #(
  parameter int NREG = 256,
  parameter int W    = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] rd_a_idx,
  output logic [W-1:0]            rd_a_data,
  input  logic [$clog2(NREG)-1:0] rd_b_idx,
  output logic [W-1:0]            rd_b_data,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [W-1:0]            wr_data,
  input  logic                    cmd_valid,
  input  logic                    cmd_op,
  input  logic [$clog2(NREG)-1:0] cmd_src,
  input  logic [$clog2(NREG)-1:0] cmd_dst,
  input  logic [$clog2(NREG)-1:0] cmd_len,
  output logic                    busy,
  output logic                    done
);
  localparam int IW = $clog2(NREG);
  localparam logic OP_SWAP = 1'b0;

  logic [W-1:0]  mem [NREG];
  logic          busy_q, done_q, up_q;
  logic [IW-1:0] sp_q, dp_q, left_q;

  function automatic logic [W-1:0] peek(input logic [IW-1:0] i);
    return (i == '0) ? '0 : mem[i];
  endfunction

  wire           accept  = cmd_valid & ~busy_q;
  wire           go_up   = cmd_dst < cmd_src;
  wire [IW-1:0]  tail    = cmd_len - 1'b1;
  wire [IW-1:0]  sp_init = go_up ? cmd_src : cmd_src + tail;
  wire [IW-1:0]  dp_init = go_up ? cmd_dst : cmd_dst + tail;
  wire [W-1:0]   sw_a    = peek(cmd_src);
  wire [W-1:0]   sw_b    = peek(cmd_dst);
  wire [W-1:0]   cp_val  = peek(sp_q);

  assign rd_a_data = peek(rd_a_idx);
  assign rd_b_data = peek(rd_b_idx);
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      up_q   <= 1'b0;
      sp_q   <= '0;
      dp_q   <= '0;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_en && wr_idx != '0) mem[wr_idx] <= wr_data;
      if (accept) begin
        if (cmd_op == OP_SWAP) begin
          if (cmd_src != '0) mem[cmd_src] <= sw_b;
          if (cmd_dst != '0) mem[cmd_dst] <= sw_a;
          done_q <= 1'b1;
        end else if (cmd_len == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          up_q   <= go_up;
          sp_q   <= sp_init;
          dp_q   <= dp_init;
          left_q <= cmd_len;
        end
      end else if (busy_q) begin
        if (dp_q != '0) mem[dp_q] <= cp_val;
        sp_q   <= up_q ? sp_q + 1'b1 : sp_q - 1'b1;
        dp_q   <= up_q ? dp_q + 1'b1 : dp_q - 1'b1;
        left_q <= left_q - 1'b1;
        if (left_q == 1) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/zreg_file_chk.sv
module zreg_file_chk #(
  parameter int IW = 8,
  parameter int W  = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] rd_a_idx,
  input logic [W-1:0]  rd_a_data,
  input logic [IW-1:0] rd_b_idx,
  input logic [W-1:0]  rd_b_data,
  input logic          cmd_valid,
  input logic          cmd_op,
  input logic [IW-1:0] cmd_len,
  input logic          busy,
  input logic          done
);
  a_r2_zero_read_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == '0 |-> rd_a_data == '0);
  a_r2_zero_read_b: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_idx == '0 |-> rd_b_data == '0);
  a_r4_swap_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && !cmd_op |=> done && !busy);
  a_r6_copy_starts: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op && cmd_len != '0 |=> busy && !done);
  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_empty_copy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op && cmd_len == '0 |=> done && !busy);
  a_r10_busy_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid |=> busy || done);
endmodule

bind zreg_file zreg_file_chk #(.IW(IW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_len(cmd_len),
  .busy(busy), .done(done)
);

// File: tb/zreg_file_test.sv
module zreg_file_test;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = 0;
  logic        wr_en = 0, cmd_valid = 0, cmd_op = 0;
  logic [7:0]  cmd_src = 0, cmd_dst = 0, cmd_len = 0;
  logic        busy, done;

  zreg_file uut (.*);

  always #10 clk = ~clk;

  typedef struct { logic [7:0] idx; logic [63:0] val; string req; } exp_t;
  exp_t        q[$];
  logic [63:0] mdl [256];
  int          nvec = 0, nbad = 0;
  bit          over = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      rd_b_idx = e.idx;
      #1;
      chk(rd_b_data === e.val, $sformatf("%s idx %0d", e.req, e.idx), rd_b_data, e.val);
    end
  end

  task automatic verify_all(input string req);
    for (int i = 0; i < 256; i++) begin
      exp_t e;
      e.idx = i[7:0]; e.val = (i == 0) ? 64'd0 : mdl[i]; e.req = req;
      q.push_back(e);
    end
    wait (q.size() == 0);
    #2;
  endtask

  task automatic do_write(input logic [7:0] i, input logic [63:0] v);
    @(negedge clk);
    wr_en = 1; wr_idx = i; wr_data = v;
    @(negedge clk);
    wr_en = 0;
    if (i != 0) mdl[i] = v;
  endtask

  task automatic do_swap(input logic [7:0] a, input logic [7:0] b, input string req);
    logic [63:0] va, vb;
    va = (a == 0) ? 64'd0 : mdl[a];
    vb = (b == 0) ? 64'd0 : mdl[b];
    @(negedge clk);
    cmd_valid = 1; cmd_op = 0; cmd_src = a; cmd_dst = b;
    @(negedge clk);
    cmd_valid = 0;
    chk(done === 1'b1 && busy === 1'b0, "R4 swap done", {62'd0, busy, done}, 64'd1);
    @(negedge clk);
    chk(done === 1'b0, "R4 done pulse width", {63'd0, done}, 64'd0);
    if (a != 0) mdl[a] = vb;
    if (b != 0) mdl[b] = va;
    verify_all(req);
  endtask

  task automatic do_copy(input logic [7:0] s, input logic [7:0] d, input logic [7:0] n,
                         input bit inject, input string req);
    logic [63:0] snap [256];
    int cyc;
    for (int i = 0; i < 256; i++) snap[i] = (i == 0) ? 64'd0 : mdl[i];
    @(negedge clk);
    cmd_valid = 1; cmd_op = 1; cmd_src = s; cmd_dst = d; cmd_len = n;
    @(negedge clk);
    cmd_valid = 0;
    if (n != 0) chk(busy === 1'b1, "R6 busy after accept", {63'd0, busy}, 64'd1);
    else        chk(busy === 1'b0, "R9 no busy on empty copy", {63'd0, busy}, 64'd0);
    cyc = 0;
    while (done !== 1'b1 && cyc < 300) begin
      if (inject && cyc == 1) begin
        cmd_valid = 1; cmd_op = 0; cmd_src = 8'd100; cmd_dst = 8'd101;
      end
      @(negedge clk);
      cmd_valid = 0;
      cyc++;
    end
    chk(cyc == int'(n), "R6 busy length", 64'(cyc), 64'(n));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R6 done single cycle", {62'd0, busy, done}, 64'd0);
    for (int i = 0; i < int'(n); i++) begin
      int si, di;
      si = (int'(s) + i) % 256;
      di = (int'(d) + i) % 256;
      if (di != 0) mdl[di] = snap[si];
    end
    verify_all(req);
  endtask

  initial begin : watchdog
    #4_000_000;
    if (!over) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 256; i++) mdl[i] = 64'd0;
    #35 rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R11 reset flags", {62'd0, busy, done}, 64'd0);
    verify_all("R11 reset contents");

    for (int i = 1; i <= 40; i++)
      do_write(i[7:0], 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0203_0405_0607));
    for (int i = 120; i < 256; i += 45) do_write(i[7:0], 64'hC3C3_0000_0000_1111 + 64'(i));
    do_write(8'd253, 64'h1234_5678_9ABC_DEF0);
    do_write(8'd254, 64'hFEDC_BA98_7654_3210);
    do_write(8'd255, 64'h0F0F_F0F0_0F0F_F0F0);
    do_write(8'd100, 64'hAAAA_0000_0000_0064);
    do_write(8'd101, 64'hBBBB_0000_0000_0065);
    do_write(8'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_a_idx = 8'd0; #1;
    chk(rd_a_data === 64'd0, "R2 port A reads zero at index 0", rd_a_data, 64'd0);
    rd_a_idx = 8'd7; #1;
    chk(rd_a_data === mdl[7], "R1 port A reads entry 7", rd_a_data, mdl[7]);
    verify_all("R1 R2 after writes");

    do_swap(8'd3, 8'd9, "R4 swap 3 and 9");
    do_swap(8'd0, 8'd0, "R5 swap 0 with 0");
    do_swap(8'd0, 8'd12, "R5 swap 0 with 12");
    do_swap(8'd14, 8'd0, "R5 swap 14 with 0");
    do_swap(8'd15, 8'd15, "R4 swap with itself");

    do_copy(8'd1, 8'd4, 8'd5, 0, "R7 overlap upward");
    do_copy(8'd10, 8'd8, 8'd6, 0, "R7 overlap downward");
    do_copy(8'd254, 8'd30, 8'd4, 0, "R8 source wraps through 0");
    do_copy(8'd20, 8'd254, 8'd4, 0, "R8 destination wraps past 0");
    do_copy(8'd2, 8'd50, 8'd0, 0, "R9 empty copy");
    do_copy(8'd30, 8'd60, 8'd6, 1, "R10 swap ignored while busy");

    @(negedge clk);
    wr_en = 1; wr_idx = 8'd5; wr_data = 64'hDEAD_BEEF_0000_0005;
    cmd_valid = 1; cmd_op = 0; cmd_src = 8'd5; cmd_dst = 8'd6;
    @(negedge clk);
    wr_en = 0; cmd_valid = 0;
    begin
      logic [63:0] t;
      t = mdl[5]; mdl[5] = mdl[6]; mdl[6] = t;
    end
    @(negedge clk);
    verify_all("R3 command write beats port write");

    over = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule